// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block is a synchronous master for a three-wire serial EEPROM that holds 16-bit words at 6-bit word addresses. A host presents an operation code, a word address and, for writes, a data word, then pulses `start`. The block builds the command frame, shifts it out on the bus with slow, evenly spaced line changes, and shifts in or out the 16-bit data word. For programming operations it then watches the memory's ready indication, giving up after a bounded number of polls.

Every change on the bus is held for `HALF_PERIOD_CYCLES` clock cycles before the next change. That interval sets the bus speed and should be sized to the memory's slowest timing. The ready poll takes one sample per interval, for at most `POLL_LIMIT` samples. The host sees `busy` for the length of an operation and a one-cycle `done` pulse at its end. A read leaves the word on `rdata`, and `timeout_err` reports a programming operation whose ready indication never came.

Top module: `mw_eeprom_master`

## Requirements
- R1: Operation codes are 0 read, 1 write, 2 erase, 3 write-enable and 4 write-disable. Each command frame is 9 bits sent most significant bit first: a 1, then a 2-bit opcode (10 read, 01 write, 11 erase, 00 enable/disable), then the 6-bit address.
- R2: The write-enable frame carries address field 111111 and the write-disable frame carries 000000, whatever `addr` holds. After a write-disable, a write leaves the memory unchanged.
- R3: `ee_cs` rises with `ee_sk` low, one interval before the first clock. `ee_di` changes only while `ee_sk` is low. Every level on `ee_cs`, `ee_sk` and `ee_di` is held for at least `HALF_PERIOD_CYCLES` cycles.
- R4: A read takes 16 bits from `ee_do` on the 16 clock pulses after the frame, most significant bit first. Each bit is sampled at the end of its clock-high interval, and `rdata` holds the word when `done` pulses.
- R5: A write sends its 16 data bits, most significant bit first, directly after the frame bits, with no gap, for 25 clocks in all.
- R6: Write and erase end with `ee_sk` low. Then `ee_cs` is dropped for one interval and raised again, and `ee_do` is polled once per interval until it reads 1. Erase sends the 9 frame bits only.
- R7: If `ee_do` never reads 1 within `POLL_LIMIT` polls, `timeout_err` is set. The next accepted start clears it.
- R8: `ee_cs` is low at the end of every operation, a timed-out one included, and `ee_cs`, `ee_sk` and `ee_di` are all low while the block is idle.
- R9: `busy` is high from the cycle after an accepted start. `done` is a single-cycle pulse, and `busy` is low in that same cycle.
- R10: A start is ignored while `busy` is high, and a start with operation code 5, 6 or 7 is ignored entirely.
- R11: After reset, all outputs are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code |
| addr | input | 6 | Word address |
| wdata | input | 16 | Word to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdata | output | 16 | Word from the last read |
| timeout_err | output | 1 | Ready never seen in the last programming operation |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready from the memory |

## Verification
Two events can meet in one cycle. A host start can arrive while an operation is running, and the poll counter can reach its last count in the same interval that ready appears. The bench injects a second start in the middle of a read. It then checks that the memory model saw exactly one frame and that the read word is intact. It also delays the model's ready so that it lands just before the final poll, expecting success, and again so that it never lands, expecting `timeout_err` with `ee_cs` low.

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master #(
  parameter int HALF_PERIOD_CYCLES = 5000,
  parameter int POLL_LIMIT         = 10000,
  parameter int ADDR_W             = 6,
  parameter int DATA_W             = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              timeout_err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int FRAME_W = ADDR_W + 3;
  localparam int SEQ_W   = FRAME_W + DATA_W;
  localparam int TMR_W   = $clog2(HALF_PERIOD_CYCLES + 1);
  localparam int LEFT_W  = $clog2(SEQ_W + 1);
  localparam int RCNT_W  = $clog2(DATA_W + 1);
  localparam int PCNT_W  = $clog2(POLL_LIMIT + 1);

  localparam logic [2:0] OP_RD = 3'd0;
  localparam logic [2:0] OP_WR = 3'd1;
  localparam logic [2:0] OP_ER = 3'd2;
  localparam logic [2:0] OP_EN = 3'd3;
  localparam logic [2:0] OP_DS = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_CLO, S_CHI, S_GAP, S_RHI, S_RLO,
    S_DESEL, S_RESEL, S_POLL, S_END
  } state_t;

  state_t            state;
  logic [TMR_W-1:0]  tmr;
  logic [SEQ_W-1:0]  shreg;
  logic [LEFT_W-1:0] left;
  logic [RCNT_W-1:0] rcnt;
  logic [PCNT_W-1:0] pcnt;
  logic [2:0]        op_q;
  logic              do_m, do_s;
  logic [1:0]        pre;
  logic [ADDR_W-1:0] fld;

  wire tick   = (tmr == TMR_W'(HALF_PERIOD_CYCLES - 1));
  wire accept = (state == S_IDLE) && start && (op <= OP_DS);

  assign busy  = (state != S_IDLE);
  assign ee_cs = !(state inside {S_IDLE, S_DESEL, S_END});
  assign ee_sk = (state == S_CHI) || (state == S_RHI);
  assign ee_di = ((state == S_CLO) || (state == S_CHI)) && shreg[SEQ_W-1];

  always_comb begin
    pre = 2'b00;
    fld = addr;
    case (op)
      OP_RD: pre = 2'b10;
      OP_WR: pre = 2'b01;
      OP_ER: pre = 2'b11;
      OP_EN: fld = '1;
      OP_DS: fld = '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      do_m <= 1'b0;
      do_s <= 1'b0;
    end else begin
      do_m <= ee_do;
      do_s <= do_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else if (state == S_IDLE || tick) tmr <= '0;
    else tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      shreg       <= '0;
      left        <= '0;
      rcnt        <= '0;
      pcnt        <= '0;
      op_q        <= OP_RD;
      rdata       <= '0;
      timeout_err <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q        <= op;
        shreg       <= {1'b1, pre, fld, wdata};
        left        <= (op == OP_WR) ? LEFT_W'(SEQ_W) : LEFT_W'(FRAME_W);
        timeout_err <= 1'b0;
        state       <= S_SEL;
      end else if (state != S_IDLE && tick) begin
        case (state)
          S_SEL: state <= S_CLO;
          S_CLO: state <= S_CHI;
          S_CHI: begin
            shreg <= shreg << 1;
            left  <= left - 1'b1;
            state <= (left == LEFT_W'(1)) ? S_GAP : S_CLO;
          end
          S_GAP: begin
            rcnt <= '0;
            if (op_q == OP_RD) state <= S_RHI;
            else if (op_q == OP_WR || op_q == OP_ER) state <= S_DESEL;
            else state <= S_END;
          end
          S_RHI: begin
            rdata <= {rdata[DATA_W-2:0], do_s};
            state <= S_RLO;
          end
          S_RLO: begin
            rcnt  <= rcnt + 1'b1;
            state <= (rcnt == RCNT_W'(DATA_W - 1)) ? S_END : S_RHI;
          end
          S_DESEL: state <= S_RESEL;
          S_RESEL: begin
            pcnt  <= '0;
            state <= S_POLL;
          end
          S_POLL: begin
            if (do_s) state <= S_END;
            else if (pcnt == PCNT_W'(POLL_LIMIT - 1)) begin
              timeout_err <= 1'b1;
              state       <= S_END;
            end else pcnt <= pcnt + 1'b1;
          end
          S_END: begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_di_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  p_sk_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> (ee_cs && $past(ee_cs)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di));

  p_err_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !ee_cs);

  p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && $past(op) <= OP_DS));

endmodule

// File: tb/mw_eeprom_master_tb.sv
module mw_eeprom_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int PLIM = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic busy, done, timeout_err, ee_cs, ee_sk, ee_di;
  logic [15:0] rdata;
  logic ee_do = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_master #(.HALF_PERIOD_CYCLES(HALF), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .timeout_err(timeout_err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  int checks = 0, errors = 0, tviol = 0, frames = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic [15:0] mem [64];
  bit we = 0, pend = 0, polling = 0;
  int pend_clks = 0, ctr = 0, busy_clks = 10, nbits = 0, rec_n = 0, run = 1000;
  logic [8:0] frame = '0, rec_frame = '0;
  logic [15:0] wsh = '0, outsh = '0;
  logic p_cs = 0, p_sk = 0, p_di = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((ee_cs != p_cs) || (ee_sk != p_sk) || (ee_di != p_di)) begin
        if (run < HALF) tviol++;
        if (ee_di != p_di && ee_sk && p_sk) tviol++;
        if (ee_sk && !p_sk && !(ee_cs && p_cs)) tviol++;
        run = 1;
      end else run++;
      if (ee_cs && !p_cs) begin
        nbits = 0;
        frame = '0;
        if (pend) begin
          polling = 1; pend = 0; ctr = 0;
          ee_do <= (pend_clks == 0);
        end
      end else if (!ee_cs && p_cs) begin
        if (polling) polling = 0;
        else begin
          rec_frame = frame; rec_n = nbits; frames++;
          if (frame[8:6] == 3'b101) begin
            if (we && nbits == 25) mem[frame[5:0]] = wsh;
            pend = 1; pend_clks = we ? busy_clks : 0;
          end else if (frame[8:6] == 3'b111) begin
            if (we && nbits == 9) mem[frame[5:0]] = 16'hFFFF;
            pend = 1; pend_clks = we ? busy_clks : 0;
          end else if (frame[8:6] == 3'b100) begin
            if (frame[5:0] == 6'h3F) we = 1;
            if (frame[5:0] == 6'h00) we = 0;
          end
        end
        ee_do <= 1'b1;
      end else if (polling && ee_cs) begin
        ctr++;
        ee_do <= (ctr >= pend_clks);
      end
      if (ee_sk && !p_sk && ee_cs) begin
        if (nbits < 9) begin
          frame = {frame[7:0], ee_di};
          if (nbits == 8 && frame[8:6] == 3'b110) outsh = mem[frame[5:0]];
        end else begin
          wsh = {wsh[14:0], ee_di};
          if (frame[8:6] == 3'b110) begin
            ee_do <= outsh[15];
            outsh = outsh << 1;
          end
        end
        nbits++;
      end
    end
    p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
  end

  task automatic run_op(input logic [2:0] o, input logic [5:0] a, input logic [15:0] w,
                        input bit spoil);
    @(negedge clk);
    start = 1; op = o; addr = a; wdata = w;
    @(negedge clk);
    start = 0;
    chk("R9 busy after start", busy, 1);
    if (spoil) begin
      repeat (20) @(negedge clk);
      start = 1; op = 3'd1; addr = ~a; wdata = ~w;
      @(negedge clk);
      start = 0;
    end
    forever begin
      @(negedge clk);
      if (done) break;
    end
    chk("R9 busy low with done", busy, 0);
    chk("R8 cs low at done", ee_cs, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0D3B) ^ 16'hA5C3);
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R11 cs", ee_cs, 0);
    chk("R11 sk", ee_sk, 0);
    chk("R11 di", ee_di, 0);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 err", timeout_err, 0);
    chk("R11 rdata", rdata, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_op(3'd3, 6'h05, 16'h0, 0);
    chk("R2 enable frame", rec_frame, 9'b100_111111);
    chk("R2 enable length", rec_n, 9);

    for (int a = 0; a < 64; a++) begin
      run_op(3'd1, 6'(a), pat(a), 0);
      chk("R1 write frame", rec_frame, {3'b101, 6'(a)});
      chk("R5 write length", rec_n, 25);
      chk("R5 write stored", mem[a], pat(a));
      chk("R6 write no error", timeout_err, 0);
    end
    for (int a = 0; a < 64; a++) begin
      run_op(3'd0, 6'(a), 16'h0, 0);
      chk("R1 read frame", rec_frame, {3'b110, 6'(a)});
      chk("R4 read word", rdata, pat(a));
    end

    run_op(3'd1, 6'h15, 16'h0000, 0);
    run_op(3'd0, 6'h15, 16'h0, 0);
    chk("R4 read zeros", rdata, 16'h0000);
    run_op(3'd2, 6'h15, 16'h0, 0);
    chk("R6 erase frame", rec_frame, 9'b111_010101);
    chk("R6 erase length", rec_n, 9);
    run_op(3'd0, 6'h15, 16'h0, 0);
    chk("R6 erase gives ones", rdata, 16'hFFFF);
    run_op(3'd2, 6'h3F, 16'h0, 0);
    run_op(3'd0, 6'h3F, 16'h0, 0);
    chk("R6 erase top word", rdata, 16'hFFFF);

    busy_clks = HALF * PLIM;
    run_op(3'd1, 6'h09, 16'h1357, 0);
    chk("R6 ready before last poll", timeout_err, 0);
    busy_clks = 1000000;
    run_op(3'd1, 6'h0A, 16'h2468, 0);
    chk("R7 timeout flagged", timeout_err, 1);
    chk("R8 cs low after timeout", ee_cs, 0);
    busy_clks = 10;
    run_op(3'd0, 6'h0A, 16'h0, 0);
    chk("R7 error cleared", timeout_err, 0);
    chk("R4 read after timeout", rdata, 16'h2468);

    run_op(3'd4, 6'h2A, 16'h0, 0);
    chk("R2 disable frame", rec_frame, 9'b100_000000);
    run_op(3'd1, 6'h03, 16'hDEAD, 0);
    run_op(3'd0, 6'h03, 16'h0, 0);
    chk("R2 write ignored when disabled", rdata, pat(3));
    run_op(3'd3, 6'h00, 16'h0, 0);

    begin
      int f0;
      f0 = frames;
      run_op(3'd0, 6'h11, 16'h0, 1);
      chk("R10 one frame despite start", frames - f0, 1);
      chk("R10 read intact", rdata, pat(17));
      f0 = frames;
      @(negedge clk);
      start = 1; op = 3'd5; addr = 6'h01;
      @(negedge clk);
      start = 0;
      repeat (3 * HALF) @(negedge clk);
      chk("R10 undefined op busy", busy, 0);
      chk("R10 undefined op cs", ee_cs, 0);
      chk("R10 undefined op frames", frames - f0, 0);
    end
    chk("R3 timing violations", tviol, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule